// File: doc/BRIEF.md
# Trip-Threshold Programming Command Decoder

This block listens next to a two-wire serial slave that has already turned the line activity into start, stop and received-byte strobes. It picks out two special write transactions that adjust a supply-supervisor trip threshold. One raises the threshold. The other clears it back to its lowest value. When one of these transactions closes with a stop, the block emits a single-cycle request to the threshold cell: a program request or an erase request. The block then stays busy until the out-of-band high-voltage qualifier is taken away.

A transaction qualifies only if three conditions hold. The high-voltage qualifier must already be present when the start is seen, and it must stay present until the stop. The write-enable latch must be set at the stop. The bytes must form exactly one of the two three-byte frames. Any deviation drops the transaction silently, with no request and no busy. The block has no path to the memory array, so neither command can touch stored data. The strobes are one-hot: at most one of start, stop and byte-valid is high in any cycle.

Top module: `trip_cmd_decoder`

## Requirements
- R1: While reset is high, and in the cycle after it is released, program_req, erase_req and busy are all low.
- R2: The frame start, 0xA0, 0x01, 0x00, stop asks for a raise. It needs the qualifier high at the start and at every cycle up to and including the stop, and the enable latch high at the stop. program_req is then high for exactly the cycle after the clock edge that samples the stop.
- R3: The same frame with 0x03 as its second byte asks for a clear under the same conditions, and pulses erase_req instead.
- R4: No request appears before the stop. The byte strobes alone never produce a request.
- R5: If the qualifier is low in the cycle the start is sampled, the frame produces no request, even if the qualifier rises later in the frame.
- R6: If the qualifier is low in any cycle between the start and the stop, the frame produces no request, even if it returns before the stop.
- R7: If the enable latch is low in the stop cycle, the frame produces no request.
- R8: A frame produces no request if it has a first byte other than 0xA0, a second byte other than 0x01 or 0x03, a third byte other than 0x00, fewer than three bytes, or more than three bytes.
- R9: A second start before the stop cancels the frame, and the closing stop produces no request.
- R10: busy rises together with a request pulse and holds while the qualifier stays high. It falls at the first clock edge that samples the qualifier low.
- R11: While busy is high, start, byte and stop strobes are ignored: no request is issued. After busy falls, a fresh valid frame is accepted again.
- R12: program_req and erase_req are never high together, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Start (or repeated start) seen on the bus, one cycle |
| bus_stop | input | 1 | Stop seen on the bus, one cycle |
| byte_vld | input | 1 | A received byte is present on byte_data, one cycle |
| byte_data | input | DATA_W | Received byte value |
| hv_present | input | 1 | High-voltage qualifier detected on the protect pin |
| wel | input | 1 | Write-enable latch state |
| program_req | output | 1 | One-cycle request to raise the threshold |
| erase_req | output | 1 | One-cycle request to clear the threshold |
| busy | output | 1 | Operation in progress, waiting for the qualifier to drop |

## Verification
The bench targets the qualifier's timing at both ends of a frame. In one case the qualifier is raised only after the start. In another it drops and comes back in the middle of a frame. A design that samples the qualifier only at the stop would wrongly fire in both. Frames of the wrong length, frames with a wrong byte and frames cut by a repeated start are sent too. A matcher that only checks a prefix, or that lets a new start reopen the frame, would issue a request there. A complete valid frame is also sent while busy, and busy is watched across the edge where the qualifier falls. This catches a design that re-arms too early or releases busy one cycle off.

// File: rtl/trip_cmd_pkg.sv
package trip_cmd_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_SET  = 2'd1,
    KIND_CLR  = 2'd2
  } trip_kind_e;

  localparam int FRAME_BYTES = 3;
endpackage

// File: rtl/trip_frame_track.sv
// Tracks whether a frame is open and whether its high-voltage qualifier
// has held continuously since the start.
module trip_frame_track (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic stop_i,
  input  logic hv_i,
  input  logic busy_i,
  output logic open_o,
  output logic qual_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      open_o <= 1'b0;
      qual_o <= 1'b0;
    end else if (!busy_i) begin
      if (start_i) begin
        open_o <= 1'b1;
        // a start inside an open frame poisons it until the stop
        qual_o <= hv_i & ~open_o;
      end else if (stop_i) begin
        open_o <= 1'b0;
        qual_o <= 1'b0;
      end else if (open_o && !hv_i) begin
        qual_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/trip_seq_match.sv
// Compares the received bytes of an open frame against the two command shapes.
module trip_seq_match
  import trip_cmd_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter logic [DATA_W-1:0] DEV_BYTE = 8'hA0,
  parameter logic [DATA_W-1:0] SET_BYTE = 8'h01,
  parameter logic [DATA_W-1:0] CLR_BYTE = 8'h03,
  parameter logic [DATA_W-1:0] DAT_BYTE = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              open_i,
  input  logic              busy_i,
  output trip_kind_e        kind_o,
  output logic              match_o
);
  localparam int IDX_W = $clog2(FRAME_BYTES + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BYTES);

  logic [IDX_W-1:0] idx_q;
  logic             bad_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      bad_q  <= 1'b0;
      kind_o <= KIND_NONE;
    end else if (!busy_i) begin
      if (start_i) begin
        idx_q  <= '0;
        bad_q  <= 1'b0;
        kind_o <= KIND_NONE;
      end else if (byte_vld_i && open_i) begin
        case (idx_q)
          IDX_W'(0): if (byte_i != DEV_BYTE) bad_q <= 1'b1;
          IDX_W'(1): begin
            if (byte_i == SET_BYTE)      kind_o <= KIND_SET;
            else if (byte_i == CLR_BYTE) kind_o <= KIND_CLR;
            else                         bad_q  <= 1'b1;
          end
          IDX_W'(2): if (byte_i != DAT_BYTE) bad_q <= 1'b1;
          default:   bad_q <= 1'b1;
        endcase
        if (idx_q != IDX_LAST) idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign match_o = (idx_q == IDX_LAST) && !bad_q && (kind_o != KIND_NONE);
endmodule

// File: rtl/trip_action_ctrl.sv
// Fires the request at the stop and holds busy until the qualifier drops.
module trip_action_ctrl
  import trip_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stop_i,
  input  logic       open_i,
  input  logic       qual_i,
  input  logic       hv_i,
  input  logic       wel_i,
  input  logic       match_i,
  input  trip_kind_e kind_i,
  output logic       prog_o,
  output logic       erase_o,
  output logic       busy_o
);
  logic fire;

  assign fire = stop_i & ~busy_o & open_i & qual_i & hv_i & wel_i & match_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_o  <= 1'b0;
      erase_o <= 1'b0;
      busy_o  <= 1'b0;
    end else begin
      prog_o  <= fire && (kind_i == KIND_SET);
      erase_o <= fire && (kind_i == KIND_CLR);
      if (busy_o && !hv_i) busy_o <= 1'b0;
      else if (fire)       busy_o <= 1'b1;
    end
  end
endmodule

// File: rtl/trip_cmd_decoder.sv
module trip_cmd_decoder
  import trip_cmd_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter logic [DATA_W-1:0] DEV_BYTE = 8'hA0,
  parameter logic [DATA_W-1:0] SET_BYTE = 8'h01,
  parameter logic [DATA_W-1:0] CLR_BYTE = 8'h03,
  parameter logic [DATA_W-1:0] DAT_BYTE = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              hv_present,
  input  logic              wel,
  output logic              program_req,
  output logic              erase_req,
  output logic              busy
);
  logic       frame_open;
  logic       frame_qual;
  logic       seq_match;
  trip_kind_e seq_kind;

  trip_frame_track u_track (
    .clk     (clk),
    .rst     (rst),
    .start_i (bus_start),
    .stop_i  (bus_stop),
    .hv_i    (hv_present),
    .busy_i  (busy),
    .open_o  (frame_open),
    .qual_o  (frame_qual)
  );

  trip_seq_match #(
    .DATA_W   (DATA_W),
    .DEV_BYTE (DEV_BYTE),
    .SET_BYTE (SET_BYTE),
    .CLR_BYTE (CLR_BYTE),
    .DAT_BYTE (DAT_BYTE)
  ) u_match (
    .clk        (clk),
    .rst        (rst),
    .start_i    (bus_start),
    .byte_vld_i (byte_vld),
    .byte_i     (byte_data),
    .open_i     (frame_open),
    .busy_i     (busy),
    .kind_o     (seq_kind),
    .match_o    (seq_match)
  );

  trip_action_ctrl u_act (
    .clk     (clk),
    .rst     (rst),
    .stop_i  (bus_stop),
    .open_i  (frame_open),
    .qual_i  (frame_qual),
    .hv_i    (hv_present),
    .wel_i   (wel),
    .match_i (seq_match),
    .kind_i  (seq_kind),
    .prog_o  (program_req),
    .erase_o (erase_req),
    .busy_o  (busy)
  );
endmodule

// File: rtl/trip_cmd_checker.sv
module trip_cmd_checker (
  input logic clk,
  input logic rst,
  input logic bus_stop,
  input logic hv_present,
  input logic wel,
  input logic program_req,
  input logic erase_req,
  input logic busy
);
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(program_req && erase_req)); // R12
  AST_PROG_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    program_req |=> !program_req); // R12
  AST_ERASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    erase_req |=> !erase_req); // R12
  AST_PROG_AT_STOP: assert property (@(posedge clk) disable iff (rst)
    program_req |-> $past(bus_stop)); // R4
  AST_ERASE_AT_STOP: assert property (@(posedge clk) disable iff (rst)
    erase_req |-> $past(bus_stop)); // R4
  AST_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
    (program_req || erase_req) |-> $past(wel)); // R7
  AST_BUSY_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (program_req || erase_req)); // R10
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && hv_present) |=> busy); // R10
  AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (busy && !hv_present) |=> !busy); // R10
  AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> !(program_req || erase_req)); // R11
endmodule

bind trip_cmd_decoder trip_cmd_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_stop    (bus_stop),
  .hv_present  (hv_present),
  .wel         (wel),
  .program_req (program_req),
  .erase_req   (erase_req),
  .busy        (busy)
);

// File: tb/test_trip_cmd_decoder.sv
`timescale 1ns/1ps
module test_trip_cmd_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_start = 1'b0, bus_stop = 1'b0, byte_vld = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       hv_present = 1'b0, wel = 1'b0;
  logic       program_req, erase_req, busy;

  int total = 0, bad = 0;
  int n_prog = 0, n_erase = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // reference model state
  bit   m_open, m_ok, m_busy, e_prog, e_erase;
  logic [7:0] q[$];

  always #10 clk = ~clk;

  trip_cmd_decoder i_trip_cmd_decoder (
    .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
    .byte_vld(byte_vld), .byte_data(byte_data), .hv_present(hv_present),
    .wel(wel), .program_req(program_req), .erase_req(erase_req), .busy(busy)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_open = 0; m_ok = 0; m_busy = 0; e_prog = 0; e_erase = 0; q.delete();
    end else begin
      e_prog = 0; e_erase = 0;
      if (m_busy) begin
        if (!hv_present) m_busy = 0;
      end else if (bus_start) begin
        m_ok = m_open ? 1'b0 : hv_present;
        m_open = 1; q.delete();
      end else if (bus_stop) begin
        if (m_open && m_ok && hv_present && wel && q.size() == 3 &&
            q[0] == 8'hA0 && q[2] == 8'h00 && (q[1] == 8'h01 || q[1] == 8'h03)) begin
          if (q[1] == 8'h01) e_prog = 1; else e_erase = 1;
          m_busy = 1;
        end
        m_open = 0; m_ok = 0;
      end else begin
        if (m_open && byte_vld) q.push_back(byte_data);
        if (m_open && !hv_present) m_ok = 0;
      end
    end
  end

  task automatic chk(input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", cur_req, what, act, exp);
    end
  endtask

  task automatic chk_int(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("program_req", program_req, rst ? 1'b0 : e_prog);
      chk("erase_req",   erase_req,   rst ? 1'b0 : e_erase);
      chk("busy",        busy,        rst ? 1'b0 : m_busy);
      if (program_req) n_prog++;
      if (erase_req)   n_erase++;
    end
  end

  task automatic pulse_start();
    @(negedge clk) bus_start = 1; @(negedge clk) bus_start = 0;
  endtask
  task automatic pulse_stop();
    @(negedge clk) bus_stop = 1; @(negedge clk) bus_stop = 0;
  endtask
  task automatic send(input logic [7:0] b);
    @(negedge clk) begin byte_vld = 1; byte_data = b; end
    @(negedge clk) byte_vld = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic frame3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    pulse_start(); send(a); send(b); send(c); pulse_stop();
  endtask
  task automatic release_hv();
    @(negedge clk) hv_present = 0;
    idle(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p0, e0;
    cur_req = "R1";
    idle(3);
    chk("busy in reset", busy, 1'b0);
    @(negedge clk) rst = 0;
    idle(1);
    chk("program_req after reset", program_req, 1'b0);

    // R2 raise command, plus R4 nothing before stop, R10 busy hold/release
    cur_req = "R2";
    hv_present = 1; wel = 1; p0 = n_prog;
    pulse_start(); send(8'hA0); send(8'h01); send(8'h00);
    cur_req = "R4";
    chk_int("requests before stop", n_prog + n_erase, p0 + n_erase);
    cur_req = "R2";
    @(negedge clk) bus_stop = 1;
    @(negedge clk) begin
      bus_stop = 0;
      chk("program_req after stop", program_req, 1'b1);
    end
    cur_req = "R12";
    @(negedge clk) chk("program_req second cycle", program_req, 1'b0);
    cur_req = "R10";
    idle(4);
    chk("busy held while hv high", busy, 1'b1);
    @(negedge clk) hv_present = 0;
    @(negedge clk) chk("busy cleared after hv low", busy, 1'b0);
    idle(2);

    // R3 clear command
    cur_req = "R3";
    hv_present = 1; e0 = n_erase;
    frame3(8'hA0, 8'h03, 8'h00); idle(2);
    chk_int("erase pulses", n_erase, e0 + 1);
    release_hv();

    // R5 qualifier raised after start
    cur_req = "R5";
    p0 = n_prog;
    pulse_start(); @(negedge clk) hv_present = 1;
    send(8'hA0); send(8'h01); send(8'h00); pulse_stop(); idle(2);
    chk_int("late qualifier", n_prog, p0);
    chk("busy late qualifier", busy, 1'b0);

    // R6 qualifier glitch mid-frame
    cur_req = "R6";
    pulse_start(); send(8'hA0);
    @(negedge clk) hv_present = 0; @(negedge clk) hv_present = 1;
    send(8'h01); send(8'h00); pulse_stop(); idle(2);
    chk_int("glitched qualifier", n_prog, p0);

    // R7 enable latch low
    cur_req = "R7";
    wel = 0;
    frame3(8'hA0, 8'h01, 8'h00); idle(2);
    chk_int("wel low", n_prog, p0);
    wel = 1;

    // R8 malformed frames
    cur_req = "R8";
    e0 = n_erase;
    frame3(8'hA2, 8'h01, 8'h00);
    frame3(8'hA0, 8'h02, 8'h00);
    frame3(8'hA0, 8'h03, 8'h01);
    pulse_start(); send(8'hA0); send(8'h01); pulse_stop();
    pulse_start(); send(8'hA0); send(8'h03); send(8'h00); send(8'h00); pulse_stop();
    idle(2);
    chk_int("malformed prog", n_prog, p0);
    chk_int("malformed erase", n_erase, e0);
    chk("busy after malformed", busy, 1'b0);

    // R9 repeated start
    cur_req = "R9";
    pulse_start(); send(8'hA0);
    pulse_start(); send(8'hA0); send(8'h01); send(8'h00); pulse_stop(); idle(2);
    chk_int("repeated start", n_prog, p0);

    // R11 commands while busy ignored, then accepted again
    cur_req = "R11";
    frame3(8'hA0, 8'h01, 8'h00); idle(1);
    chk_int("setup pulse", n_prog, p0 + 1);
    frame3(8'hA0, 8'h03, 8'h00); frame3(8'hA0, 8'h01, 8'h00); idle(2);
    chk_int("busy ignores prog", n_prog, p0 + 1);
    chk_int("busy ignores erase", n_erase, e0);
    chk("still busy", busy, 1'b1);
    release_hv();
    @(negedge clk) hv_present = 1;
    frame3(8'hA0, 8'h03, 8'h00); idle(2);
    chk_int("accepted after busy", n_erase, e0 + 1);
    release_hv();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule